// File: doc/BRIEF.md
# Microprogram Sequencer with Skip and Hold

This block steps through a 256-word control store of 36-bit horizontal micro-instructions. It keeps an 8-bit microstep address and a pipeline register with the micro-instruction now executing. The next word is read from the store and loaded in the same clock edge that retires the current step, so the following step begins without a bubble. A type field in each word selects one of four step families: plain sequential steps, sequential steps that issue a special command, unconditional jumps, and conditional jumps on either a selectable condition line or a bit of an external transmit register. The target of a jump is the concatenation of two 4-bit literal fields.

A skip-select field can cancel the next micro-order. The cancel fires when the ALU result is all ones, or when the step's test bit is true, or when it is false. A cancelled word is still fetched, but it has no effect: its strobes stay low, it does not jump and it does not request a skip. A step marked arithmetic takes one extra clock. A step marked hold stays in place until an external completion strobe is seen. The ALU, register file and bus sit outside the block. They receive the current word and the write and command strobes.

Top module: `useq_top`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes to address 0 with a no-op word (all zeros) in the pipeline. The first clock edge with rst_n high loads the word at address 0 and leaves upc at 0.
- R2: The word layout, MSB to LSB, is: kind[35:33], arith[32], alu op[31:28], carry[27:26], skip select[25:24], register select[23:20], hold[19], next-select source[18], Y select[17:16], M[15:12], literal high[11:8], literal low[7:4], special-literal enable[3], write select[2:0]. The jump target is bits [11:4].
- R3: The stored word at address a is built from a: kind=a[2:0], arith=a[3], alu op=a[7:4], carry=a[1:0], skip select=a[5:4], register select=a[7:4], hold=a[7]&a[4], next-select source=a[0], Y select=a[1:0], M=a[6:3], target=(a+29) mod 256, special-literal enable=a[0], write select=a[5:3]. uword shows the word at upc once the pipeline has been loaded.
- R4: Kinds 0 and 1 go on to upc+1 (mod 256). Kind 1 also pulses cmd_valid on its retiring cycle, and cmd_code then equals literal high.
- R5: Kinds 2 and 3 jump to the target.
- R6: Kind 4 jumps when cond_in[M] is 1 and kind 5 jumps when it is 0. Otherwise the next address is upc+1.
- R7: Kind 6 jumps when xreg_in[M] is 1 and kind 7 jumps when it is 0. Otherwise the next address is upc+1.
- R8: The test bit is xreg_in[M] for kinds 6 and 7 and cond_in[M] for all other kinds. Skip select 1 cancels the next word when alu_res is all ones, 2 cancels it when the test bit is 1, 3 cancels it when the test bit is 0, and 0 never cancels. A cancelled word shows squashed=1, raises neither wr_en nor cmd_valid, retires in one cycle, goes to upc+1 and requests no skip.
- R9: A live word with arith=1 takes two cycles. Its first cycle never retires.
- R10: A live word with hold=1 raises wait_o once any stretch cycle is over. It stays in place while done_in is 0 and retires in the first cycle where done_in is 1.
- R11: wr_en is high only in the retiring cycle of a live word whose write select is nonzero. wr_sel shows the write select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_in | input | 16 | Condition lines selected by M |
| xreg_in | input | 16 | Transmit register bits tested by kinds 6 and 7 |
| alu_res | input | 16 | ALU result for the all-ones skip test |
| done_in | input | 1 | Completion strobe that releases a hold |
| upc | output | 8 | Address of the executing word |
| uword | output | 36 | Executing micro-instruction |
| squashed | output | 1 | Executing word was cancelled by a skip |
| wait_o | output | 1 | Step is held waiting for done_in |
| wr_en | output | 1 | Write strobe of the retiring step |
| wr_sel | output | 3 | Write destination field |
| cmd_valid | output | 1 | Special command strobe |
| cmd_code | output | 4 | Special command code |

## Verification
wr_en, cmd_valid, cmd_code and wait_o are combinational on the current word and inputs. They are due in the same cycle the inputs are driven. upc, uword and squashed change at the first edge after a retiring cycle. An arithmetic word needs two edges, and a held word needs the edge after done_in rises. The bench drives inputs on the falling edge and compares one nanosecond later against a cycle model of its own. It advances that model only at the rising edge, so each result is compared in exactly the cycle it is due.

// File: rtl/useq_pkg.sv
// Package: shared constants and the micro-instruction layout of the sequencer.
// Assumes a fixed 36-bit word and an 8-bit store address.
package useq_pkg;
    localparam int ADDR_W   = 8;
    localparam int WORD_W   = 36;
    localparam int TGT_BIAS = 29;

    typedef struct packed {
        logic [2:0] kind;
        logic       arith;
        logic [3:0] aluop;
        logic [1:0] carry;
        logic [1:0] skipsel;
        logic [3:0] regsel;
        logic       hold;
        logic       nxsrc;
        logic [1:0] ysel;
        logic [3:0] mfield;
        logic [3:0] lhi;
        logic [3:0] llo;
        logic       zlit;
        logic [2:0] wsel;
    } uword_t;

    localparam uword_t NOP_WORD = '0;
endpackage

// File: rtl/useq_rom.sv
// Module: control store. Combinational read of a computed 2**ADDR_W-word store.
// Assumes the contents are a fixed function of the address (see brief R3).
module useq_rom
    import useq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);
    logic [ADDR_W-1:0] tgt;

    // Build the stored word for the addressed location.
    always_comb begin
        tgt          = addr + ADDR_W'(TGT_BIAS);
        word.kind    = addr[2:0];
        word.arith   = addr[3];
        word.aluop   = addr[7:4];
        word.carry   = addr[1:0];
        word.skipsel = addr[5:4];
        word.regsel  = addr[7:4];
        word.hold    = addr[7] & addr[4];
        word.nxsrc   = addr[0];
        word.ysel    = addr[1:0];
        word.mfield  = addr[6:3];
        word.lhi     = tgt[7:4];
        word.llo     = tgt[3:0];
        word.zlit    = addr[0];
        word.wsel    = addr[5:3];
    end
endmodule

// File: rtl/useq_next.sv
// Module: next-address and skip-request logic for the executing word.
// Assumes COND_N and XREG_W cover every value of the 4-bit M field.
module useq_next
    import useq_pkg::*;
#(
    parameter int COND_N = 16,
    parameter int XREG_W = 16,
    parameter int ALU_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              live,
    input  logic [2:0]        kind,
    input  logic [1:0]        skipsel,
    input  logic [3:0]        mfield,
    input  logic [ADDR_W-1:0] target,
    input  logic [COND_N-1:0] cond_in,
    input  logic [XREG_W-1:0] xreg_in,
    input  logic [ALU_W-1:0]  alu_res,
    output logic [ADDR_W-1:0] nxt,
    output logic              skip_req
);
    logic test;

    // Pick the test bit: transmit register for kinds 6/7, condition lines otherwise.
    always_comb test = (kind[2:1] == 2'b11) ? xreg_in[mfield] : cond_in[mfield];

    // Choose the following address from the step family.
    always_comb begin
        nxt = pc + ADDR_W'(1);
        if (live) begin
            unique case (kind)
                3'd2, 3'd3: nxt = target;
                3'd4, 3'd6: if (test)  nxt = target;
                3'd5, 3'd7: if (!test) nxt = target;
                default:    nxt = pc + ADDR_W'(1);
            endcase
        end
    end

    // Decide whether the next micro-order is to be cancelled.
    always_comb begin
        skip_req = 1'b0;
        if (live) begin
            unique case (skipsel)
                2'd1:    skip_req = &alu_res;
                2'd2:    skip_req = test;
                2'd3:    skip_req = !test;
                default: skip_req = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/useq_ctl.sv
// Module: step timing. Stretches arithmetic steps by one cycle and holds steps
// that wait for the completion strobe. Assumes the stretch comes before the wait.
module useq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic arith,
    input  logic hold,
    input  logic done_in,
    output logic advance,
    output logic stretch,
    output logic waiting
);
    logic ph_q;

    // Derive stretch, wait and retire from the phase and the word flags.
    always_comb begin
        stretch = live && arith && !ph_q;
        waiting = live && hold && !stretch;
        advance = !stretch && (!waiting || done_in);
    end

    // Track whether the extra arithmetic cycle has been spent.
    always_ff @(posedge clk) begin
        if (!rst_n)       ph_q <= 1'b0;
        else if (advance) ph_q <= 1'b0;
        else if (stretch) ph_q <= 1'b1;
    end

    // R9
    stretch_then_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |=> (ph_q && !stretch));
endmodule

// File: rtl/useq_top.sv
// Module: microprogram sequencer top. Holds the address and pipeline registers,
// reads the store at the chosen next address and retires a word per step.
// Assumes the next word is loaded on the same edge the current one retires.
module useq_top
    import useq_pkg::*;
#(
    parameter int COND_N = 16,
    parameter int XREG_W = 16,
    parameter int ALU_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COND_N-1:0]   cond_in,
    input  logic [XREG_W-1:0]   xreg_in,
    input  logic [ALU_W-1:0]    alu_res,
    input  logic                done_in,
    output logic [ADDR_W-1:0]   upc,
    output logic [WORD_W-1:0]   uword,
    output logic                squashed,
    output logic                wait_o,
    output logic                wr_en,
    output logic [2:0]          wr_sel,
    output logic                cmd_valid,
    output logic [3:0]          cmd_code
);
    uword_t            mir_q;
    uword_t            rom_word;
    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] fetch_a;
    logic              primed_q;
    logic              skip_q;
    logic              skip_req;
    logic              live;
    logic              advance;
    logic              stretch;

    // A word takes effect only once the pipeline is loaded and it was not cancelled.
    always_comb live = primed_q && !skip_q;

    useq_next #(.COND_N(COND_N), .XREG_W(XREG_W), .ALU_W(ALU_W)) i_next (
        .pc(upc_q), .live(live), .kind(mir_q.kind), .skipsel(mir_q.skipsel),
        .mfield(mir_q.mfield), .target({mir_q.lhi, mir_q.llo}),
        .cond_in(cond_in), .xreg_in(xreg_in), .alu_res(alu_res),
        .nxt(nxt), .skip_req(skip_req)
    );

    useq_ctl i_ctl (
        .clk(clk), .rst_n(rst_n), .live(live), .arith(mir_q.arith),
        .hold(mir_q.hold), .done_in(done_in),
        .advance(advance), .stretch(stretch), .waiting(wait_o)
    );

    // Fetch address: replay the reset address for the first load, else the next one.
    always_comb fetch_a = primed_q ? nxt : upc_q;

    useq_rom i_rom (.addr(fetch_a), .word(rom_word));

    // Load address, pipeline word and skip flag when the current step retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc_q    <= '0;
            mir_q    <= NOP_WORD;
            primed_q <= 1'b0;
            skip_q   <= 1'b0;
        end else if (advance) begin
            upc_q    <= fetch_a;
            mir_q    <= rom_word;
            primed_q <= 1'b1;
            skip_q   <= skip_req;
        end
    end

    // Drive the strobes of the retiring step and the visible state.
    always_comb begin
        upc       = upc_q;
        uword     = mir_q;
        squashed  = skip_q;
        wr_sel    = mir_q.wsel;
        cmd_code  = mir_q.lhi;
        wr_en     = live && advance && (mir_q.wsel != 3'd0);
        cmd_valid = live && advance && (mir_q.kind == 3'd1);
    end

    // R8
    squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squashed |-> (!wr_en && !cmd_valid));

    // R8
    squash_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squashed && primed_q) |=> (upc == $past(upc) + ADDR_W'(1)));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && !done_in) |=> ($stable(upc) && $stable(uword)));

    // R9
    stretch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |=> ($stable(upc) && $stable(uword)));

    // R5
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && live && (mir_q.kind[2:1] == 2'b01)) |=>
        (upc == $past({mir_q.lhi, mir_q.llo})));
endmodule

// File: tb/test_useq_top.sv
// Bench: cycle model of the sequencer driven by random and directed stimulus.
module test_useq_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cond_in = '0;
    logic [15:0] xreg_in = '0;
    logic [15:0] alu_res = '0;
    logic        done_in = 1'b0;
    logic [7:0]  upc;
    logic [35:0] uword;
    logic        squashed, wait_o, wr_en, cmd_valid;
    logic [2:0]  wr_sel;
    logic [3:0]  cmd_code;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [7:0] mp;
    logic       mprim, mskip, mph;
    string      last_tag;

    always #(PERIOD/2) clk = ~clk;

    useq_top i_useq_top (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .xreg_in(xreg_in),
        .alu_res(alu_res), .done_in(done_in), .upc(upc), .uword(uword),
        .squashed(squashed), .wait_o(wait_o), .wr_en(wr_en), .wr_sel(wr_sel),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    // Stored word for address a, built from the layout in R2 and content in R3.
    function automatic logic [35:0] exp_word(input logic [7:0] a);
        logic [7:0] t;
        t = a + 8'd29;
        return {a[2:0], a[3], a[7:4], a[1:0], a[5:4], a[7:4], a[7] & a[4],
                a[0], a[1:0], a[6:3], t, a[0], a[5:3]};
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mp = 8'd0; mprim = 1'b0; mskip = 1'b0; mph = 1'b0; last_tag = "R1";
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic cycle(input logic rst_v, input logic [15:0] c, input logic [15:0] x,
                         input logic [15:0] al, input logic dn);
        logic [35:0] w;
        logic        live, strt, ewait, adv, test, ewr, ecmd, nskip;
        logic [7:0]  tgt, npc;
        logic [2:0]  kind;
        logic [3:0]  m;
        @(negedge clk);
        rst_n = rst_v; cond_in = c; xreg_in = x; alu_res = al; done_in = dn;
        #1;
        w     = mprim ? exp_word(mp) : 36'd0;
        kind  = w[35:33];
        m     = w[15:12];
        tgt   = w[11:4];
        live  = mprim && !mskip;
        strt  = live && w[32] && !mph;
        ewait = live && w[19] && !strt;
        adv   = !strt && (!ewait || dn);
        test  = (kind >= 3'd6) ? x[m] : c[m];
        ewr   = live && adv && (w[2:0] != 3'd0);
        ecmd  = live && adv && (kind == 3'd1);
        chk(upc == mp, last_tag, "upc", 36'(upc), 36'(mp));
        chk(uword == w, "R3", "uword", uword, w);
        chk(squashed == mskip, "R8", "squashed", 36'(squashed), 36'(mskip));
        chk(wait_o == ewait, "R10", "wait_o", 36'(wait_o), 36'(ewait));
        chk(wr_en == ewr, mskip ? "R8" : "R11", "wr_en", 36'(wr_en), 36'(ewr));
        chk(wr_sel == w[2:0], "R11", "wr_sel", 36'(wr_sel), 36'(w[2:0]));
        chk(cmd_valid == ecmd, mskip ? "R8" : "R4", "cmd_valid", 36'(cmd_valid), 36'(ecmd));
        if (ecmd) chk(cmd_code == tgt[7:4], "R4", "cmd_code", 36'(cmd_code), 36'(tgt[7:4]));
        // next model state
        npc = mp + 8'd1;
        nskip = 1'b0;
        if (live) begin
            case (kind)
                3'd2, 3'd3: npc = tgt;
                3'd4, 3'd6: if (test)  npc = tgt;
                3'd5, 3'd7: if (!test) npc = tgt;
                default: ;
            endcase
            case (w[25:24])
                2'd1: nskip = &al;
                2'd2: nskip = test;
                2'd3: nskip = !test;
                default: nskip = 1'b0;
            endcase
        end
        @(posedge clk);
        if (!rst_v) model_reset();
        else if (adv) begin
            if (!mprim)      last_tag = "R1";
            else if (!live)  last_tag = "R8";
            else if (kind <= 3'd1) last_tag = "R4";
            else if (kind <= 3'd3) last_tag = "R5";
            else if (kind <= 3'd5) last_tag = "R6";
            else last_tag = "R7";
            mp = mprim ? npc : mp;
            mskip = nskip; mprim = 1'b1; mph = 1'b0;
        end else begin
            last_tag = strt ? "R9" : "R10";
            if (strt) mph = 1'b1;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (2) @(posedge clk);
        // R1: reset state then first load of address 0
        for (int i = 0; i < 3; i++) cycle(1'b0, '0, '0, '0, 1'b0);
        // R4 R5 R6 R7 R8 R9 R10 R11: random conditions with frequent completion
        for (int i = 0; i < 6000; i++) begin
            logic [15:0] al;
            al = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
            cycle(1'b1, 16'($urandom), 16'($urandom), al, ($urandom_range(0, 2) != 0));
        end
        // R1: reset in the middle of a run
        for (int i = 0; i < 2; i++) cycle(1'b0, 16'($urandom), 16'($urandom), '0, 1'b1);
        // R10: completion strobe rare, long holds; R8 all-ones skips always armed
        for (int i = 0; i < 3000; i++)
            cycle(1'b1, 16'($urandom), 16'($urandom), 16'hFFFF, ($urandom_range(0, 15) == 0));
        // R6 R7: all conditions high, then all low
        for (int i = 0; i < 800; i++) cycle(1'b1, 16'hFFFF, 16'hFFFF, '0, 1'b1);
        for (int i = 0; i < 800; i++) cycle(1'b1, 16'h0000, 16'h0000, '0, 1'b1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule